// File: doc/BRIEF.md
# SPI Flash Page-Program Sequencer

This block is an SPI master for a serial NOR flash that shares its clock and data lines with other devices, each of which has its own active-low select line. One start pulse runs the whole write: it reads the status register, sends write-enable, reads the status register again to confirm that the write-enable latch is set, and then programs a page. The block drives every select line itself, so each frame is framed exactly. In particular, the program frame is released on the byte boundary right after the last data bit has been sampled. A flash that sees its select released in the middle of a byte rejects the command.

The caller gives a device index, a 24-bit start address and a byte count. Payload bytes are fetched through an index/data lookup: the block presents an index and reads the byte on the data input in the same cycle. When the sequence ends, the block raises a one-cycle done pulse. An error flag accompanies that pulse when the request was refused or when the write-enable latch did not read back as set.

Top module: `spi_pp_seq`

## Requirements
- R1: A valid request produces exactly four select-framed transactions on the chosen device, with first bytes 0x05, 0x06, 0x05 and 0x02 in that order. The two status reads are 16 bits long and the write-enable frame is 8 bits long.
- R2: The bus runs in mode 0. `sclk` is low whenever every select is high, `mosi` does not change while `sclk` is high, and `miso` is sampled as `sclk` rises, most significant bit first.
- R3: At most one select line is low at any time, and only the line whose index matches `dev` is ever driven low.
- R4: Every select release happens on a byte boundary. The number of `sclk` rising edges within a frame is a multiple of 8, and `sclk` is already low when the select rises.
- R5: The program frame holds its select low without a break for 8·(4+len) clocks. It sends 0x02, then the address with its most significant byte first, then payload bytes 0 to len-1 in index order, as read on `pay_din` at `pay_idx`.
- R6: Bit 1 of the status byte in the second status read is the write-enable latch. If that bit is 0, the block does not send the program frame, and it pulses `done` with `error`.
- R7: Between the end of one frame and the start of the next, all selects stay high for at least GAP system clocks (default 2).
- R8: A request is refused with `done` and `error` in the cycle after `start`, and with no bus activity, in any of these cases: `len` is 0, `len` is above PAGE (256), `addr[7:0]+len` exceeds PAGE (the frame would cross a page), or `dev` is not below NDEV.
- R9: `busy` is high from the cycle after an accepted `start` until the sequence ends. A `start` that arrives while `busy` is high is ignored.
- R10: `done` is a single-cycle pulse, `busy` is low while it is high, and `error` is high only together with `done`.
- R11: After reset, all selects are high, and `sclk`, `busy`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| dev | input | DW (2) | Target device index |
| addr | input | 24 | Program start address |
| len | input | NW (9) | Payload byte count, 1..PAGE |
| pay_din | input | 8 | Payload byte at index `pay_idx` |
| pay_idx | output | IW (8) | Index of the payload byte being fetched |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | NDEV (4) | One active-low select line per device |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Refused request or latch not set, valid with `done` |

## Verification
The checker looks at the bus on every cycle. It confirms that `sclk` is idle while no select is active, that `mosi` holds steady while `sclk` is high, that no more than one select is low, that the `sclk` rising edges in each frame count to a multiple of eight, and that the inter-frame gap is never shorter than GAP. It also checks the timing rules among done, error and busy. Other properties depend on the content of whole frames and can only be shown by the bench's scenarios, using a flash model that records each frame. These are the opcode order, the address and payload bytes, which device line was used, whether the program frame is skipped when the latch reads back as 0, and whether a refused or overlapping request leaves the bus silent.

// File: rtl/spi_pp_seq.sv
module spi_pp_seq #(
  parameter int NDEV = 4,
  parameter int DIV  = 2,
  parameter int GAP  = 2,
  parameter int PAGE = 256,
  localparam int DW  = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int NW  = $clog2(PAGE + 1),
  localparam int IW  = $clog2(PAGE),
  localparam int TW  = $clog2(((DIV > GAP) ? DIV : GAP) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   dev,
  input  logic [23:0]     addr,
  input  logic [NW-1:0]   len,
  input  logic [7:0]      pay_din,
  output logic [IW-1:0]   pay_idx,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NDEV-1:0] cs_n,
  output logic            busy,
  output logic            done,
  output logic            error
);
  typedef enum logic [1:0] {S_IDLE, S_GAP, S_LO, S_HI} st_t;
  localparam logic [1:0] P_RS1 = 2'd0, P_WEN = 2'd1, P_RS2 = 2'd2, P_PP = 2'd3;

  st_t            st;
  logic [TW-1:0]  tcnt;
  logic [1:0]     ph;
  logic [NW:0]    bi, nb, tlen, pm, sum;
  logic [2:0]     bitc;
  logic [7:0]     sh, rx, nbyte, fbyte;
  logic [DW-1:0]  dsel;
  logic [23:0]    a_q;
  logic [NW-1:0]  n_q;
  logic [NDEV-1:0] csr;
  logic           sclk_r, done_r, err_r, last, req_ok;

  assign nb      = bi + 1'b1;
  assign pm      = bi - (NW+1)'(3);
  assign pay_idx = pm[IW-1:0];
  assign sum     = (NW+1)'(addr[IW-1:0]) + (NW+1)'(len);
  assign req_ok  = (len != '0) && ((NW+1)'(len) <= (NW+1)'(PAGE)) &&
                   (sum <= (NW+1)'(PAGE)) && (int'(dev) < NDEV);

  always_comb begin
    case (ph)
      P_WEN:   tlen = (NW+1)'(1);
      P_PP:    tlen = (NW+1)'(n_q) + (NW+1)'(4);
      default: tlen = (NW+1)'(2);
    endcase
  end
  assign last = (nb == tlen);

  always_comb begin
    case (ph)
      P_WEN:   fbyte = 8'h06;
      P_PP:    fbyte = 8'h02;
      default: fbyte = 8'h05;
    endcase
  end

  always_comb begin
    nbyte = 8'h00;
    if (ph == P_PP) begin
      case (nb)
        (NW+1)'(1): nbyte = a_q[23:16];
        (NW+1)'(2): nbyte = a_q[15:8];
        (NW+1)'(3): nbyte = a_q[7:0];
        default:    nbyte = pay_din;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; ph <= P_RS1; bi <= '0; bitc <= '0;
      sh <= '0; rx <= '0; dsel <= '0; a_q <= '0; n_q <= '0;
      csr <= '1; sclk_r <= 1'b0; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (req_ok) begin
            dsel <= dev; a_q <= addr; n_q <= len;
            ph <= P_RS1; tcnt <= '0; st <= S_GAP;
          end else begin
            done_r <= 1'b1; err_r <= 1'b1;
          end
        end
        S_GAP: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(GAP - 1)) begin
            tcnt <= '0; bi <= '0; bitc <= '0; sh <= fbyte;
            csr  <= ~(NDEV'(1) << dsel);
            st   <= S_LO;
          end
        end
        S_LO: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(DIV - 1)) begin
            tcnt <= '0; sclk_r <= 1'b1; rx <= {rx[6:0], miso}; st <= S_HI;
          end
        end
        S_HI: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(DIV - 1)) begin
            tcnt   <= '0;
            sclk_r <= 1'b0;
            st     <= S_LO;
            if (bitc == 3'd7) begin
              bitc <= '0;
              if (last) begin
                csr <= '1;
                if ((ph == P_RS2 && !rx[1]) || ph == P_PP) begin
                  st <= S_IDLE; done_r <= 1'b1; err_r <= (ph == P_RS2);
                end else begin
                  ph <= ph + 1'b1; st <= S_GAP;
                end
              end else begin
                bi <= nb; sh <= nbyte;
              end
            end else begin
              bitc <= bitc + 1'b1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sclk  = sclk_r;
  assign mosi  = sh[7];
  assign cs_n  = csr;
  assign busy  = (st != S_IDLE);
  assign done  = done_r;
  assign error = err_r;
endmodule

// File: rtl/spi_pp_seq_chk.sv
module spi_pp_seq_chk #(
  parameter int NDEV = 4,
  parameter int GAP  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk,
  input logic            mosi,
  input logic [NDEV-1:0] cs_n,
  input logic            busy,
  input logic            done,
  input logic            error
);
  logic       sclk_q;
  logic [2:0] rcnt;
  int         gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; rcnt <= '0; gcnt <= GAP;
    end else begin
      sclk_q <= sclk;
      if (&cs_n) rcnt <= '0;
      else if (sclk && !sclk_q) rcnt <= rcnt + 1'b1;
      if (!(&cs_n)) gcnt <= 0;
      else if (gcnt < GAP) gcnt <= gcnt + 1;
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (&cs_n) |-> !sclk);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi));
  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1);
  // R4
  byte_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) ((&cs_n) && !$past(&cs_n)) |-> (rcnt == 3'd0));
  // R7
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (!(&cs_n) && $past(&cs_n)) |-> (gcnt >= GAP));
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) error |-> done);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
endmodule

bind spi_pp_seq spi_pp_seq_chk #(.NDEV(NDEV), .GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .busy(busy), .done(done), .error(error)
);

// File: tb/sim_spi_pp_seq.sv
module sim_spi_pp_seq;
  localparam int PER  = 10;
  localparam int NDEV = 4;
  localparam int GAP  = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] dev = '0;
  logic [23:0] addr = '0;
  logic [8:0] len = '0;
  logic [7:0] pay_din;
  logic [7:0] pay_idx;
  logic sclk, mosi, miso, busy, done, error;
  logic [NDEV-1:0] cs_n;

  logic [7:0] mem [0:255];
  assign pay_din = mem[pay_idx];

  always #(PER/2) clk = ~clk;

  spi_pp_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .dev(dev), .addr(addr),
    .len(len), .pay_din(pay_din), .pay_idx(pay_idx), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .busy(busy), .done(done), .error(error));

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // Flash model: records each frame
  logic [7:0] tb_byte [0:7][0:299];
  int tr_bits [0:7];
  int tr_dev [0:7];
  int ntr = 0, bitn = 0;
  logic [7:0] shin = '0;
  logic wel = 1'b0, block_wel = 1'b0, gap_bad = 1'b0;
  logic [NDEV-1:0] cs_q = '1;
  time last_rise = 0;

  assign miso = (ntr < 8 && bitn >= 8 && bitn < 16 && tb_byte[ntr][0] == 8'h05)
                ? (((bitn == 14) && wel) ? 1'b1 : 1'b0) : 1'b0;

  always @(posedge sclk) begin
    shin = {shin[6:0], mosi};
    bitn = bitn + 1;
    if (bitn % 8 == 0 && ntr < 8 && bitn / 8 <= 300) tb_byte[ntr][bitn/8 - 1] = shin;
  end

  always @(cs_n) begin
    if (cs_n != '1 && cs_q == '1) begin
      bitn = 0;
      if (last_rise != 0 && ($time - last_rise) < GAP * PER) gap_bad = 1'b1;
      for (int i = 0; i < NDEV; i++) if (!cs_n[i] && ntr < 8) tr_dev[ntr] = i;
    end else if (cs_n == '1 && cs_q != '1) begin
      last_rise = $time;
      if (ntr < 8) begin
        tr_bits[ntr] = bitn;
        if (bitn == 8 && tb_byte[ntr][0] == 8'h06 && !block_wel) wel = 1'b1;
        if (tb_byte[ntr][0] == 8'h02) wel = 1'b0;
      end
      ntr = ntr + 1;
    end
    cs_q = cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  task automatic kick(input int d, input logic [23:0] a, input int n);
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 13 + d + 5);
    ntr = 0; wel = 1'b0;
    dev = 2'(d); addr = a; len = 9'(n);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit got_err, output bit timed_out);
    timed_out = 1;
    got_err = 0;
    for (int c = 0; c < 20000; c++) begin
      if (done) begin timed_out = 0; got_err = error; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_frames(input int d, input logic [23:0] a, input int n, input string tag);
    chk(ntr == 4, "R1", {tag, " frame count"}, ntr, 4);
    if (ntr != 4) return;
    chk(tb_byte[0][0] == 8'h05 && tr_bits[0] == 16, "R1", {tag, " first status read"}, tr_bits[0], 16);
    chk(tb_byte[1][0] == 8'h06 && tr_bits[1] == 8, "R1", {tag, " write enable"}, tr_bits[1], 8);
    chk(tb_byte[2][0] == 8'h05 && tr_bits[2] == 16, "R1", {tag, " second status read"}, tr_bits[2], 16);
    chk(tb_byte[3][0] == 8'h02, "R1", {tag, " program opcode"}, tb_byte[3][0], 2);
    chk(tr_bits[3] == 8 * (4 + n), "R5", {tag, " program length bits"}, tr_bits[3], 8 * (4 + n));
    chk({tb_byte[3][1], tb_byte[3][2], tb_byte[3][3]} == a, "R5", {tag, " address msb first"},
        int'({tb_byte[3][1], tb_byte[3][2], tb_byte[3][3]}), int'(a));
    begin
      int bad = -1;
      for (int k = 0; k < n; k++) if (tb_byte[3][4 + k] != mem[k] && bad < 0) bad = k;
      chk(bad < 0, "R5", {tag, " payload order (first bad index)"}, bad, -1);
    end
    begin
      int wrong = 0;
      for (int t = 0; t < 4; t++) if (tr_dev[t] != d) wrong++;
      chk(wrong == 0, "R3", {tag, " select line used"}, tr_dev[3], d);
    end
    chk(tr_bits[0] % 8 == 0 && tr_bits[3] % 8 == 0, "R4", {tag, " byte boundary release"}, tr_bits[3] % 8, 0);
    chk(!gap_bad, "R7", {tag, " inter-frame gap"}, gap_bad, 0);
  endtask

  task automatic t_reset();
    chk(cs_n == '1, "R11", "selects after reset", cs_n, 4'hF);
    chk(!sclk && !busy && !done && !error, "R11", "outputs after reset",
        {sclk, busy, done, error}, 0);
  endtask

  task automatic t_good(input int d, input logic [23:0] a, input int n, input string tag);
    bit e, to;
    kick(d, a, n);
    chk(busy, "R9", {tag, " busy after start"}, busy, 1);
    wait_done(e, to);
    chk(!to, "R9", {tag, " finished"}, to, 0);
    chk(!e, "R10", {tag, " no error"}, e, 0);
    @(negedge clk);
    chk(!done && !busy, "R10", {tag, " done single pulse"}, {done, busy}, 0);
    check_frames(d, a, n, tag);
  endtask

  task automatic t_refuse(input int d, input logic [23:0] a, input int n, input string tag);
    bit e, to;
    kick(d, a, n);
    chk(done && error && !busy, "R8", {tag, " refused at once"}, {done, error, busy}, 6);
    wait_done(e, to);
    repeat (40) @(negedge clk);
    chk(ntr == 0 && cs_n == '1, "R8", {tag, " no bus activity"}, ntr, 0);
  endtask

  task automatic t_wel_fail();
    bit e, to;
    block_wel = 1'b1;
    kick(1, 24'h000400, 8);
    wait_done(e, to);
    chk(!to && e, "R6", "latch clear gives error", e, 1);
    repeat (40) @(negedge clk);
    chk(ntr == 3, "R6", "no program frame after clear latch", ntr, 3);
    chk(ntr < 3 || tb_byte[2][0] == 8'h05, "R6", "last frame is status read", tb_byte[2][0], 5);
    chk(cs_n == '1, "R6", "selects high after refusal", cs_n, 4'hF);
    block_wel = 1'b0;
  endtask

  task automatic t_busy_ignore();
    bit e, to;
    kick(0, 24'h100020, 3);
    repeat (30) @(negedge clk);
    dev = 2'd2; addr = 24'h000000; len = 9'd1;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    dev = 2'd0; addr = 24'h100020; len = 9'd3;
    wait_done(e, to);
    chk(!to && !e, "R9", "run with extra start", e, 0);
    repeat (40) @(negedge clk);
    chk(!busy, "R9", "no second run started", busy, 0);
    check_frames(0, 24'h100020, 3, "busy-ignore");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good(0, 24'h012340, 4, "basic");
    t_good(3, 24'hABCD00, 256, "full page");
    t_good(2, 24'h0000FF, 1, "last byte of page");
    t_refuse(1, 24'h0000FF, 2, "page cross");
    t_refuse(0, 24'h000010, 0, "zero length");
    t_refuse(0, 24'h000000, 257, "over page");
    t_wel_fail();
    t_busy_ignore();
    summary();
  end
endmodule